// File: doc/BRIEF.md
# DDR2 Power-Down Mode Controller

This block follows a DDR2-style memory device into and out of its power-down
states. Each clock it samples the registered clock-enable level, the decoded
command on the bus, whether every bank is closed, whether a read or write burst
is still moving data, the on-die termination level and a configuration bit that
selects fast or slow exit from active power-down.

The block decides whether a low clock-enable is a legal entry. It then reports
one of three modes: awake, precharge power-down (no bank open at entry) or
active power-down (a row open at entry). It also reports whether the
delay-locked loop stays running and whether the input clock frequency may be
changed. An illegal drop of clock-enable raises a one-cycle error flag and
leaves the mode unchanged. A memory controller or a checking model uses the
outputs to gate its own clock-change and exit sequencing.

Top module: `ddr_pd_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pd_mode` is 2'b00 (awake), `dll_on` is 1, `freq_ok` is 0 and `entry_err` is 0.
- R2: When the block is awake and a clock edge samples `cke` low with `cmd` equal to NOP (4'h0) or deselect (4'h1), and nothing blocks entry, `pd_mode` becomes 2'b01 (precharge power-down) if `all_idle` is 1, or 2'b10 (active power-down) if it is 0.
- R3: When the block is awake and an edge samples `cke` low with any command other than NOP or deselect, `entry_err` is 1 for the next cycle and `pd_mode` stays 2'b00. Examples of such commands are read 4'h8 and activate 4'h4.
- R4: When the block is awake and an edge samples `cke` low while `burst_busy` is 1, the same error response as R3 applies.
- R5: A mode register (4'h2) or extended mode register (4'h3) command blocks entry for the next MRD_CYC edges (default 2), with the error response of R3. After that, entry is legal again.
- R6: `dll_on` is 1 when awake and 0 in precharge power-down. In active power-down it equals the `fast_exit` value sampled at the entry edge. Later changes of `fast_exit` have no effect until the next entry.
- R7: In either power-down mode, an edge that samples `cke` high returns `pd_mode` to 2'b00 after that edge.
- R8: `freq_ok` is 1 only in precharge power-down with `odt` 0 and `cke` 0, once at least FREQ_WAIT edges (default 2) have passed after the entry edge.
- R9: While in power-down with `cke` low, `cmd`, `burst_busy` and `all_idle` do not change `pd_mode`, and `entry_err` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Registered clock-enable level |
| cmd | input | 4 | Decoded command code |
| all_idle | input | 1 | 1 when no bank has an open row |
| burst_busy | input | 1 | 1 while a read or write burst is moving data |
| odt | input | 1 | On-die termination level |
| fast_exit | input | 1 | 1 selects fast exit from active power-down |
| pd_mode | output | 2 | 00 awake, 01 precharge power-down, 10 active power-down |
| dll_on | output | 1 | DLL held enabled |
| freq_ok | output | 1 | Input clock frequency change permitted |
| entry_err | output | 1 | One-cycle flag for an illegal clock-enable drop |

## Verification
Two functions can act on the same edge. The first is the countdown that blocks
entry after a mode-register command. The second is the entry decision, whose
low clock-enable arrives while that countdown is still running. The bench
issues a mode-register write and then holds clock-enable low with NOP on each
following edge. The error flag must show on exactly the first MRD_CYC edges,
and precharge power-down must follow on the edge after.

The second overlap is in power-down. There, a command, burst flag and idle
flag that would be illegal when awake arrive on the same edge as a held-low
clock-enable. These are judged by the mode staying put and no error being
raised.

// File: rtl/ddr_pd_pkg.sv
// Shared types and command codes for the DDR2 power-down controller.
// Assumes the command decoder upstream produces the 4-bit codes below.
package ddr_pd_pkg;

    typedef enum logic [1:0] {
        PD_AWAKE = 2'b00,
        PD_PRE   = 2'b01,
        PD_ACT   = 2'b10
    } pd_mode_e;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_NOP   = 4'h0;
    localparam logic [CMD_W-1:0] CMD_DESEL = 4'h1;
    localparam logic [CMD_W-1:0] CMD_MRS   = 4'h2;
    localparam logic [CMD_W-1:0] CMD_EMRS  = 4'h3;
    localparam logic [CMD_W-1:0] CMD_ACT   = 4'h4;
    localparam logic [CMD_W-1:0] CMD_PRE   = 4'h5;
    localparam logic [CMD_W-1:0] CMD_PREA  = 4'h6;
    localparam logic [CMD_W-1:0] CMD_REF   = 4'h7;
    localparam logic [CMD_W-1:0] CMD_RD    = 4'h8;
    localparam logic [CMD_W-1:0] CMD_WR    = 4'h9;
    localparam logic [CMD_W-1:0] CMD_RDA   = 4'hA;
    localparam logic [CMD_W-1:0] CMD_WRA   = 4'hB;

endpackage

// File: rtl/ddr_pd_guard.sv
// Entry guard: decides whether a low clock-enable may start power-down.
// It holds a countdown after mode-register commands and flags illegal
// drops of clock-enable while awake.
// Assumes cmd is valid on every edge; burst_busy covers all burst data.
module ddr_pd_guard
    import ddr_pd_pkg::*;
#(
    parameter int MRD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [CMD_W-1:0] cmd,
    input  logic             burst_busy,
    input  logic             awake,
    output logic             entry_ok,
    output logic             entry_err
);
    localparam int MRD_W = $clog2(MRD_CYC + 1);
    localparam logic [MRD_W-1:0] MRD_LOAD = MRD_W'(MRD_CYC);

    logic [MRD_W-1:0] mrd_cnt;
    logic             is_mode_cmd;
    logic             is_quiet_cmd;
    logic             blocked;

    // Classify the command on the bus.
    always_comb begin
        is_mode_cmd  = (cmd == CMD_MRS) || (cmd == CMD_EMRS);
        is_quiet_cmd = (cmd == CMD_NOP) || (cmd == CMD_DESEL);
        blocked      = burst_busy || (mrd_cnt != '0);
        entry_ok     = is_quiet_cmd && !blocked;
    end

    // Count down the mode-register command time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrd_cnt <= '0;
        end else if (is_mode_cmd) begin
            mrd_cnt <= MRD_LOAD;
        end else if (mrd_cnt != '0) begin
            mrd_cnt <= mrd_cnt - 1'b1;
        end
    end

    // Flag a low clock-enable that arrives while entry is not legal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_err <= 1'b0;
        end else begin
            entry_err <= awake && !cke && !entry_ok;
        end
    end

    // R5
    mode_cmd_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode_cmd |=> !entry_ok);

    // R4
    busy_drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (awake && !cke && burst_busy) |=> entry_err);

endmodule

// File: rtl/ddr_pd_fsm.sv
// Power-down mode state machine. It moves between awake, precharge
// power-down and active power-down. At entry it latches the exit speed and
// derives the DLL hold state. Assumes entry_ok comes from the entry guard.
module ddr_pd_fsm
    import ddr_pd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cke,
    input  logic     entry_ok,
    input  logic     all_idle,
    input  logic     fast_exit,
    output pd_mode_e mode,
    output logic     dll_on
);
    pd_mode_e state_q;
    pd_mode_e state_d;
    logic     fast_q;

    // Next-state choice from clock-enable and the guard verdict.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_AWAKE: if (!cke && entry_ok) state_d = all_idle ? PD_PRE : PD_ACT;
            PD_PRE,
            PD_ACT:   if (cke) state_d = PD_AWAKE;
            default:  state_d = PD_AWAKE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PD_AWAKE;
        else        state_q <= state_d;
    end

    // Capture the exit speed on the entry edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else if (state_q == PD_AWAKE && state_d != PD_AWAKE) begin
            fast_q <= fast_exit;
        end
    end

    // DLL stays running when awake or in fast-exit active power-down.
    always_comb begin
        mode   = state_q;
        dll_on = (state_q == PD_AWAKE) || (state_q == PD_ACT && fast_q);
    end

    // R2
    entry_needs_low_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == PD_AWAKE && state_q != PD_AWAKE) |-> !$past(cke));

    // R7
    exit_on_high_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PD_AWAKE && cke) |=> state_q == PD_AWAKE);

    // R9
    pd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PD_AWAKE && !cke) |=> $stable(state_q));

endmodule

// File: rtl/ddr_pd_freq.sv
// Frequency-change permit: counts edges spent in power-down since entry.
// It allows a clock change only in precharge power-down with termination
// off and clock-enable low. Assumes mode comes from the state machine.
module ddr_pd_freq
    import ddr_pd_pkg::*;
#(
    parameter int FREQ_WAIT = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pd_mode_e mode,
    input  logic     cke,
    input  logic     odt,
    output logic     freq_ok
);
    localparam int WAIT_W = $clog2(FREQ_WAIT + 1);
    localparam logic [WAIT_W-1:0] WAIT_MAX = WAIT_W'(FREQ_WAIT);

    logic [WAIT_W-1:0] low_cnt;

    // Saturating count of edges in power-down; cleared while awake.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == PD_AWAKE) begin
            low_cnt <= '0;
        end else if (low_cnt != WAIT_MAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Permit only after the wait, in precharge power-down, quiet pins.
    always_comb begin
        freq_ok = (mode == PD_PRE) && (low_cnt == WAIT_MAX) && !odt && !cke;
    end

    // R8
    freq_conditions_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_ok |-> (mode == PD_PRE && !odt && !cke));

endmodule

// File: rtl/ddr_pd_ctrl.sv
// Top of the DDR2 power-down mode controller. It ties the entry guard, the
// mode state machine and the frequency-change permit together.
// Assumes cke is the already-registered clock-enable level.
module ddr_pd_ctrl
    import ddr_pd_pkg::*;
#(
    parameter int MRD_CYC   = 2,
    parameter int FREQ_WAIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke,
    input  logic [3:0] cmd,
    input  logic       all_idle,
    input  logic       burst_busy,
    input  logic       odt,
    input  logic       fast_exit,
    output logic [1:0] pd_mode,
    output logic       dll_on,
    output logic       freq_ok,
    output logic       entry_err
);
    pd_mode_e mode;
    logic     entry_ok;
    logic     awake;

    // Awake indication for the guard.
    always_comb begin
        awake   = (mode == PD_AWAKE);
        pd_mode = mode;
    end

    ddr_pd_guard #(.MRD_CYC(MRD_CYC)) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cmd        (cmd),
        .burst_busy (burst_busy),
        .awake      (awake),
        .entry_ok   (entry_ok),
        .entry_err  (entry_err)
    );

    ddr_pd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .entry_ok  (entry_ok),
        .all_idle  (all_idle),
        .fast_exit (fast_exit),
        .mode      (mode),
        .dll_on    (dll_on)
    );

    ddr_pd_freq #(.FREQ_WAIT(FREQ_WAIT)) u_freq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .cke     (cke),
        .odt     (odt),
        .freq_ok (freq_ok)
    );

    // R3
    err_keeps_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_err |-> pd_mode == 2'b00);

    // R6
    pre_pd_dll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_mode == 2'b01 |-> !dll_on);

endmodule

// File: tb/ddr_pd_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for ddr_pd_ctrl: a vector table walked by one loop, then directed
// reset checks.
module ddr_pd_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cke;
    logic [3:0] cmd;
    logic       all_idle;
    logic       burst_busy;
    logic       odt;
    logic       fast_exit;
    logic [1:0] pd_mode;
    logic       dll_on;
    logic       freq_ok;
    logic       entry_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    ddr_pd_ctrl u_ddr_pd_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cmd        (cmd),
        .all_idle   (all_idle),
        .burst_busy (burst_busy),
        .odt        (odt),
        .fast_exit  (fast_exit),
        .pd_mode    (pd_mode),
        .dll_on     (dll_on),
        .freq_ok    (freq_ok),
        .entry_err  (entry_err)
    );

    // Vector: cke, cmd[3:0], all_idle, burst_busy, odt, fast_exit |
    //         expected pd_mode[1:0], dll_on, freq_ok, entry_err (after the edge)
    localparam int NV = 32;
    localparam logic [13:0] VEC [NV] = '{
        14'b1_0000_1_0_0_0_00_1_0_0, // 0  awake
        14'b0_0000_1_0_0_0_01_0_0_0, // 1  enter precharge PD
        14'b0_0000_1_0_0_0_01_0_0_0, // 2  one edge since entry
        14'b0_0000_1_0_0_0_01_0_1_0, // 3  permit after two edges
        14'b0_0000_1_0_1_0_01_0_0_0, // 4  odt on blocks permit
        14'b1_0000_1_0_0_0_00_1_0_0, // 5  exit
        14'b0_1000_1_0_0_0_00_1_0_1, // 6  low cke with read -> error
        14'b1_0000_1_0_0_0_00_1_0_0, // 7  error clears
        14'b0_0000_1_1_0_0_00_1_0_1, // 8  low cke during burst -> error
        14'b0_0000_0_0_0_0_10_0_0_0, // 9  enter active PD, slow exit
        14'b0_0000_1_0_0_1_10_0_0_0, // 10 fast_exit change ignored
        14'b0_0000_1_0_0_0_10_0_0_0, // 11 no permit in active PD
        14'b1_0000_1_0_0_0_00_1_0_0, // 12 exit
        14'b0_0000_0_0_0_1_10_1_0_0, // 13 active PD, fast exit
        14'b1_0000_1_0_0_0_00_1_0_0, // 14 exit
        14'b1_0010_1_0_0_0_00_1_0_0, // 15 mode register write
        14'b0_0000_1_0_0_0_00_1_0_1, // 16 blocked, window edge 1
        14'b0_0000_1_0_0_0_00_1_0_1, // 17 blocked, window edge 2
        14'b0_0000_1_0_0_0_01_0_0_0, // 18 entry legal again
        14'b0_0001_1_0_0_0_01_0_0_0, // 19 deselect held
        14'b0_0000_1_0_0_0_01_0_1_0, // 20 permit
        14'b1_0000_1_0_0_0_00_1_0_0, // 21 exit
        14'b1_0011_1_0_0_0_00_1_0_0, // 22 extended mode register write
        14'b1_0000_1_0_0_0_00_1_0_0, // 23
        14'b1_0000_1_0_0_0_00_1_0_0, // 24 window elapsed while cke high
        14'b0_0000_1_0_0_0_01_0_0_0, // 25 entry legal
        14'b1_0000_1_0_0_0_00_1_0_0, // 26 exit
        14'b0_0001_0_0_0_0_10_0_0_0, // 27 entry with deselect, active PD
        14'b0_0100_1_1_0_0_10_0_0_0, // 28 activity ignored in PD
        14'b1_0000_1_0_0_0_00_1_0_0, // 29 exit
        14'b0_0100_1_0_0_0_00_1_0_1, // 30 low cke with activate -> error
        14'b1_0000_1_0_0_0_00_1_0_0  // 31
    };

    task automatic check1(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic check2(input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic apply(input logic [13:0] v);
        cke        = v[13];
        cmd        = v[12:9];
        all_idle   = v[8];
        burst_busy = v[7];
        odt        = v[6];
        fast_exit  = v[5];
    endtask

    task automatic check_reset_state(input string tag);
        check2({tag, " R1 pd_mode"},   pd_mode,   2'b00);
        check1({tag, " R1 dll_on"},    dll_on,    1'b1);
        check1({tag, " R1 freq_ok"},   freq_ok,   1'b0);
        check1({tag, " R1 entry_err"}, entry_err, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0;
        apply(14'b1_0000_1_0_0_0_00_0_0_0);
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive on the falling edge, check after the rising edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(posedge clk);
            #1;
            check2($sformatf("vec%0d R2 R7 R9 pd_mode", i), pd_mode, VEC[i][4:3]);
            check1($sformatf("vec%0d R6 dll_on", i), dll_on, VEC[i][2]);
            check1($sformatf("vec%0d R8 freq_ok", i), freq_ok, VEC[i][1]);
            check1($sformatf("vec%0d R3 R4 R5 entry_err", i), entry_err, VEC[i][0]);
        end

        // Directed: reset while in precharge power-down with permit active.
        @(negedge clk);
        apply(14'b0_0000_1_0_0_0_00_0_0_0);
        repeat (3) @(posedge clk);
        #1;
        check1("directed R8 freq_ok before reset", freq_ok, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_reset_state("midpd");

        // Directed: reset clears an error and the mode-register countdown.
        @(negedge clk);
        rst_n = 1'b1;
        apply(14'b1_0010_1_0_0_0_00_0_0_0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(14'b0_0000_1_0_0_0_00_0_0_0);
        @(posedge clk);
        #1;
        check2("directed R5 R1 countdown cleared by reset", pd_mode, 2'b01);
        check1("directed R5 R1 no error after reset", entry_err, 1'b0);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule